// File: doc/BRIEF.md
# Carry-Save Multiplier Sequencer with Compute-in-Memory Timing

This block multiplies two unsigned W-bit operands and paces the work as an array of memory-resident logic would run it. A job goes through three phases. One cycle builds the W shifted partial-product rows. A run of 3:2 carry-save layers then cuts those rows down to two, and no carry ripples during this phase. A final carry-propagate pass over the 2W-bit pair then gives the product. Row shifts belong to the wiring between row groups and cost no cycles. Each 3:2 layer costs one slot of SLOT cycles, the price of one 1-bit add. The final pass also costs one slot per result bit.

In exact mode the final pass covers all 2W bits. In approximate mode the low W bits are the bitwise OR of the two reduced rows, taken with no carry. Only the upper W bits are added serially, which halves the final phase. The error is bounded and is stated below. The number of layers S is the greedy 3:2 count for W rows: every full triple of rows becomes two rows and leftover rows pass through unchanged. For W=8 this gives 8, 6, 4, 3, 2 rows, so S=4.

A job is accepted when `in_valid` and `in_ready` are both high at a clock edge. `in_ready` is high only while the block is idle, and nothing can be queued behind a running job. The result is offered with `out_valid`. The product and the cycle count stay stable until `out_ready` is sampled high, so the consumer can stall the block for as long as it needs. A new job can be accepted only after that output handshake.

Top module: `csa_mul_seq`

## Requirements
- R1: In exact mode (`in_approx`=0 at acceptance), `out_product` equals `in_a`×`in_b` as a 2W-bit unsigned value.
- R2: In exact mode, `out_valid` first rises exactly 1 + SLOT×S + SLOT×2W cycles after the acceptance edge, and `out_cycles` reports that same value (261 for W=8, SLOT=13).
- R3: In approximate mode, `out_valid` first rises exactly 1 + SLOT×S + SLOT×W cycles after acceptance, and `out_cycles` reports that same value (157 for W=8, SLOT=13).
- R4: In approximate mode, the exact product minus `out_product` lies in the range 0 to 2^W − 1 inclusive.
- R5: In approximate mode, the product is exact when at most one partial-product row is nonzero, that is when `in_b` is zero or has exactly one bit set.
- R6: `in_ready` is low from acceptance until the output handshake. An `in_valid` seen while busy is not taken, and the running job's result does not change.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_product` and `out_cycles` hold. On the cycle after the output handshake, `out_valid` is low and `in_ready` is high.
- R8: During and right after reset, `in_ready`=1, `out_valid`=0 and `out_cycles`=0.
- R9: `out_valid` rises exactly once for each accepted job and never without one.
- R10: The operands and the mode bit are sampled only at the acceptance edge. Changing them while busy changes neither the product nor the latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Job request |
| in_ready | output | 1 | High while idle; a job is taken when in_valid is also high |
| in_a | input | W | Multiplicand |
| in_b | input | W | Multiplier |
| in_approx | input | 1 | 1 selects the approximate final add |
| out_valid | output | 1 | Result available, held until out_ready |
| out_ready | input | 1 | Consumer takes the result |
| out_product | output | 2W | Product |
| out_cycles | output | CNT_W | Compute cycles spent on the job |

## Verification
The bench builds the block with W=8 and SLOT=13. That gives four reduction layers, and the layers see leftover rows of two, zero and one as the row count falls from eight to two. The reduced rows carry real overlapping carries at this size, so the approximate error bound is exercised with nonzero error as well as at zero. At this width every job completes in at most a few hundred cycles, so exact and approximate jobs, stalls and busy-time request pokes can all be mixed within a short run.

// File: rtl/csa_mul_pkg.sv
`timescale 1ns/1ps
package csa_mul_pkg;

  // rows left after one greedy 3:2 layer
  function automatic int rows_after(input int r);
    if (r <= 2) return r;
    return 2 * (r / 3) + (r % 3);
  endfunction

  // rows present at the input of layer s
  function automatic int rows_at(input int r0, input int s);
    int r;
    r = r0;
    for (int i = 0; i < s; i++) r = rows_after(r);
    return r;
  endfunction

  // layers needed to bring r0 rows down to two
  function automatic int layer_count(input int r0);
    int r;
    int n;
    r = r0;
    n = 0;
    while (r > 2) begin
      r = rows_after(r);
      n++;
    end
    return n;
  endfunction

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PPGEN,
    ST_REDUCE,
    ST_FINAL,
    ST_DONE
  } phase_e;

endpackage

// File: rtl/pp_rows.sv
`timescale 1ns/1ps
module pp_rows #(
  parameter int W = 8
) (
  input  logic [W-1:0]            a,
  input  logic [W-1:0]            b,
  output logic [W-1:0][2*W-1:0]   rows
);
  localparam int PW = 2 * W;

  for (genvar i = 0; i < W; i++) begin : g_row
    // shift is wiring only: row i is a placed i columns up
    assign rows[i] = b[i] ? (PW'(a) << i) : '0;
  end
endmodule

// File: rtl/csa_layer.sv
`timescale 1ns/1ps
module csa_layer #(
  parameter int W       = 8,
  parameter int ROWS_IN = 8,
  parameter int ROWS_OUT = 2 * (ROWS_IN / 3) + (ROWS_IN % 3)
) (
  input  logic [ROWS_IN-1:0][2*W-1:0]  rin,
  output logic [ROWS_OUT-1:0][2*W-1:0] rout
);
  localparam int PW     = 2 * W;
  localparam int GROUPS = ROWS_IN / 3;
  localparam int LEFT   = ROWS_IN % 3;

  for (genvar g = 0; g < GROUPS; g++) begin : g_triple
    logic [PW-1:0] x, y, z;
    assign x = rin[3*g];
    assign y = rin[3*g+1];
    assign z = rin[3*g+2];
    assign rout[2*g]   = x ^ y ^ z;
    // majority moves one column up; the top column never carries out
    assign rout[2*g+1] = {(x[PW-2:0] & y[PW-2:0]) | (x[PW-2:0] & z[PW-2:0]) |
                          (y[PW-2:0] & z[PW-2:0]), 1'b0};
  end

  for (genvar l = 0; l < LEFT; l++) begin : g_pass
    assign rout[2*GROUPS+l] = rin[3*GROUPS+l];
  end
endmodule

// File: rtl/serial_cpa.sv
`timescale 1ns/1ps
module serial_cpa #(
  parameter int W = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clear,
  input  logic           step,
  input  logic           approx,
  input  logic [2*W-1:0] x,
  input  logic [2*W-1:0] y,
  output logic [2*W-1:0] sum,
  output logic           last
);
  localparam int PW    = 2 * W;
  localparam int IDX_W = $clog2(PW);

  logic [PW-1:0]    acc;
  logic [IDX_W-1:0] idx;
  logic             carry;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc   <= '0;
      idx   <= '0;
      carry <= 1'b0;
    end else if (clear) begin
      acc   <= '0;
      carry <= 1'b0;
      idx   <= approx ? IDX_W'(W) : '0;
    end else if (step) begin
      acc[idx] <= x[idx] ^ y[idx] ^ carry;
      carry    <= (x[idx] & y[idx]) | (x[idx] & carry) | (y[idx] & carry);
      idx      <= idx + IDX_W'(1);
    end
  end

  assign last = (idx == IDX_W'(PW - 1));
  // approximate low half: carry-free OR of the two rows
  assign sum  = {acc[PW-1:W], approx ? (x[W-1:0] | y[W-1:0]) : acc[W-1:0]};
endmodule

// File: rtl/csa_mul_seq.sv
`timescale 1ns/1ps
module csa_mul_seq
  import csa_mul_pkg::*;
#(
  parameter int W     = 8,
  parameter int SLOT  = 13,
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [W-1:0]     in_a,
  input  logic [W-1:0]     in_b,
  input  logic             in_approx,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [2*W-1:0]   out_product,
  output logic [CNT_W-1:0] out_cycles
);
  localparam int PW        = 2 * W;
  localparam int NSTAGE    = layer_count(W);
  localparam int NLAY      = (NSTAGE > 0) ? NSTAGE : 1;
  localparam int SLOT_W    = (SLOT > 1) ? $clog2(SLOT) : 1;
  localparam int STG_W     = (NSTAGE > 1) ? $clog2(NSTAGE) : 1;

  phase_e             state;
  logic [W-1:0]       a_q, b_q;
  logic               approx_q;
  logic [W-1:0][PW-1:0] rows_q;
  logic [W-1:0][PW-1:0] pp_w;
  logic [W-1:0][PW-1:0] layer_out [NLAY];
  logic [SLOT_W-1:0]  slot_q;
  logic [STG_W-1:0]   stg_q;
  logic [CNT_W-1:0]   cyc_q;
  logic               slot_end;
  logic               cpa_clear, cpa_step, cpa_last;

  pp_rows #(.W(W)) u_pp (.a(a_q), .b(b_q), .rows(pp_w));

  if (NSTAGE > 0) begin : g_reduce
    for (genvar s = 0; s < NSTAGE; s++) begin : g_layer
      localparam int RIN  = rows_at(W, s);
      localparam int ROUT = rows_after(RIN);
      logic [ROUT-1:0][PW-1:0] lo;
      csa_layer #(.W(W), .ROWS_IN(RIN)) u_layer (
        .rin  (rows_q[RIN-1:0]),
        .rout (lo)
      );
      assign layer_out[s] = {{((W - ROUT) * PW){1'b0}}, lo};
    end
  end else begin : g_noreduce
    assign layer_out[0] = rows_q;
  end

  serial_cpa #(.W(W)) u_cpa (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (cpa_clear),
    .step   (cpa_step),
    .approx (approx_q),
    .x      (rows_q[0]),
    .y      (rows_q[1]),
    .sum    (out_product),
    .last   (cpa_last)
  );

  assign slot_end  = (slot_q == SLOT_W'(SLOT - 1));
  assign cpa_clear = (state == ST_PPGEN);
  assign cpa_step  = (state == ST_FINAL) && slot_end;
  assign in_ready  = (state == ST_IDLE);
  assign out_valid = (state == ST_DONE);
  assign out_cycles = cyc_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      a_q      <= '0;
      b_q      <= '0;
      approx_q <= 1'b0;
      rows_q   <= '0;
      slot_q   <= '0;
      stg_q    <= '0;
      cyc_q    <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (in_valid) begin
            a_q      <= in_a;
            b_q      <= in_b;
            approx_q <= in_approx;
            cyc_q    <= '0;
            state    <= ST_PPGEN;
          end
        end
        ST_PPGEN: begin
          rows_q <= pp_w;
          cyc_q  <= cyc_q + CNT_W'(1);
          slot_q <= '0;
          stg_q  <= '0;
          state  <= (NSTAGE > 0) ? ST_REDUCE : ST_FINAL;
        end
        ST_REDUCE: begin
          cyc_q <= cyc_q + CNT_W'(1);
          if (slot_end) begin
            slot_q <= '0;
            rows_q <= layer_out[stg_q];
            if (stg_q == STG_W'(NSTAGE - 1)) state <= ST_FINAL;
            else stg_q <= stg_q + STG_W'(1);
          end else begin
            slot_q <= slot_q + SLOT_W'(1);
          end
        end
        ST_FINAL: begin
          cyc_q <= cyc_q + CNT_W'(1);
          if (slot_end) begin
            slot_q <= '0;
            if (cpa_last) state <= ST_DONE;
          end else begin
            slot_q <= slot_q + SLOT_W'(1);
          end
        end
        ST_DONE: begin
          if (out_ready) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/csa_mul_seq_chk.sv
`timescale 1ns/1ps
module csa_mul_seq_chk
  import csa_mul_pkg::*;
#(
  parameter int W     = 8,
  parameter int SLOT  = 13,
  parameter int CNT_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic [W-1:0]     in_a,
  input logic [W-1:0]     in_b,
  input logic             in_approx,
  input logic             out_valid,
  input logic             out_ready,
  input logic [2*W-1:0]   out_product,
  input logic [CNT_W-1:0] out_cycles
);
  localparam int PW    = 2 * W;
  localparam int NS    = layer_count(W);
  localparam int LAT_X = 1 + SLOT * NS + SLOT * PW;
  localparam int LAT_A = 1 + SLOT * NS + SLOT * W;

  logic             pending;
  logic [W-1:0]     a_c, b_c;
  logic             mode_c;
  logic [CNT_W:0]   elapsed;
  logic [PW-1:0]    exact_c;
  logic [PW:0]      gap;

  assign exact_c = PW'(a_c) * PW'(b_c);
  assign gap     = {1'b0, exact_c} - {1'b0, out_product};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pending <= 1'b0;
      a_c     <= '0;
      b_c     <= '0;
      mode_c  <= 1'b0;
      elapsed <= '0;
    end else begin
      if (in_valid && in_ready) begin
        pending <= 1'b1;
        a_c     <= in_a;
        b_c     <= in_b;
        mode_c  <= in_approx;
        elapsed <= '0;
      end else if (out_valid && out_ready) begin
        pending <= 1'b0;
      end else if (pending && !out_valid) begin
        elapsed <= elapsed + (CNT_W+1)'(1);
      end
    end
  end

  p_exact_product_r1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !mode_c |-> out_product == exact_c);

  p_exact_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) && !mode_c |-> out_cycles == CNT_W'(LAT_X) && elapsed == (CNT_W+1)'(LAT_X));

  p_approx_latency_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) && mode_c |-> out_cycles == CNT_W'(LAT_A) && elapsed == (CNT_W+1)'(LAT_A));

  p_approx_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && mode_c |-> gap < ((PW+1)'(1) << W));

  p_approx_single_row_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && mode_c && $onehot0(b_c) |-> out_product == exact_c);

  p_busy_not_ready_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pending |-> !in_ready);

  p_hold_output_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_product) && $stable(out_cycles));

  p_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready |=> !out_valid && in_ready);

  p_valid_owned_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> pending);
endmodule

bind csa_mul_seq csa_mul_seq_chk #(.W(W), .SLOT(SLOT), .CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .in_a        (in_a),
  .in_b        (in_b),
  .in_approx   (in_approx),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_product (out_product),
  .out_cycles  (out_cycles)
);

// File: tb/tb_csa_mul_seq.sv
`timescale 1ns/1ps
module tb_csa_mul_seq;
  localparam int W     = 8;
  localparam int PW    = 2 * W;
  localparam int SLOT  = 13;
  localparam int CNT_W = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [W-1:0] in_a = '0;
  logic [W-1:0] in_b = '0;
  logic in_approx = 1'b0;
  logic out_valid;
  logic out_ready = 1'b0;
  logic [PW-1:0] out_product;
  logic [CNT_W-1:0] out_cycles;

  always #2.5 clk = ~clk;

  csa_mul_seq #(.W(W), .SLOT(SLOT), .CNT_W(CNT_W)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_a(in_a), .in_b(in_b), .in_approx(in_approx), .out_valid(out_valid),
    .out_ready(out_ready), .out_product(out_product), .out_cycles(out_cycles)
  );

  typedef struct {
    logic [W-1:0] a;
    logic [W-1:0] b;
    logic         apx;
    int           acc;
    int           lat;
  } item_t;

  item_t sbq[$];
  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int nres = 0;
  bit finished = 1'b0;
  logic [15:0] lf = 16'hACE1;

  always @(posedge clk) cyc <= cyc + 1;

  // layers counted from the row count: each layer removes one row per full triple
  function automatic int layers_for(input int n);
    int r;
    int k;
    r = n;
    k = 0;
    while (r > 2) begin
      r = r - r / 3;
      k++;
    end
    return k;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic send(input logic [W-1:0] a, input logic [W-1:0] b,
                      input logic apx, input bit poke);
    item_t it;
    @(negedge clk);
    in_valid = 1'b1; in_a = a; in_b = b; in_approx = apx;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    it.a = a; it.b = b; it.apx = apx; it.acc = cyc;
    it.lat = 1 + SLOT * layers_for(W) + SLOT * (apx ? W : PW);
    sbq.push_back(it);
    if (poke) begin
      // R6 / R10: request held with other values while busy
      in_a = ~a; in_b = b + 8'd1; in_approx = ~apx;
      for (int k = 0; k < 5; k++) begin
        check(in_ready == 1'b0, "R6", "in_ready while busy", in_ready, 0);
        @(negedge clk);
      end
    end
    in_valid = 1'b0;
  endtask

  // monitor and scoreboard
  initial begin
    item_t it;
    logic [PW-1:0] snap_p;
    logic [CNT_W-1:0] snap_c;
    longint expv;
    longint diff;
    forever begin
      @(negedge clk);
      if (rst_n && out_valid) begin
        if (sbq.size() == 0) begin
          check(1'b0, "R9", "out_valid without job", 1, 0);
        end else begin
          it = sbq.pop_front();
          expv = longint'(it.a) * longint'(it.b);
          check((cyc - it.acc) == it.lat, it.apx ? "R3" : "R2", "latency",
                cyc - it.acc, it.lat);
          check(out_cycles == CNT_W'(it.lat), it.apx ? "R3" : "R2", "out_cycles",
                out_cycles, it.lat);
          if (!it.apx) begin
            check(out_product == PW'(expv), "R1", "exact product", out_product, expv);
          end else begin
            diff = expv - longint'(out_product);
            check(diff >= 0 && diff < (64'd1 << W), "R4", "approx error", diff, 0);
            if ($onehot0(it.b))
              check(out_product == PW'(expv), "R5", "single-row approx", out_product, expv);
          end
          snap_p = out_product;
          snap_c = out_cycles;
          for (int s = 0; s < nres % 3; s++) begin
            out_ready = 1'b0;
            @(negedge clk);
            check(out_valid == 1'b1 && out_product == snap_p && out_cycles == snap_c,
                  "R7", "hold under stall", out_product, snap_p);
          end
          out_ready = 1'b1;
          @(negedge clk);
          out_ready = 1'b0;
          check(out_valid == 1'b0 && in_ready == 1'b1, "R7", "release after handshake",
                {out_valid, in_ready}, 1);
          nres++;
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      errors++;
      $display("FAIL R9 watchdog actual=%0d expected=%0d", nres, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(in_ready == 1'b1 && out_valid == 1'b0 && out_cycles == '0, "R8",
          "reset state", {in_ready, out_valid}, 2);
    rst_n = 1'b1;
    @(negedge clk);
    check(in_ready == 1'b1 && out_valid == 1'b0 && out_cycles == '0, "R8",
          "after reset", {in_ready, out_valid}, 2);

    send(8'd0,   8'd0,   1'b0, 1'b0);
    send(8'd255, 8'd255, 1'b0, 1'b0);
    send(8'd255, 8'd255, 1'b1, 1'b0);
    send(8'd1,   8'd1,   1'b0, 1'b0);
    send(8'd200, 8'd0,   1'b1, 1'b0);
    send(8'd123, 8'd64,  1'b1, 1'b0);
    send(8'd77,  8'd1,   1'b1, 1'b0);
    send(8'd255, 8'd128, 1'b1, 1'b0);
    send(8'd13,  8'd11,  1'b0, 1'b1);
    send(8'd170, 8'd85,  1'b1, 1'b1);
    send(8'd255, 8'd127, 1'b1, 1'b0);
    for (int n = 0; n < 30; n++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      send(lf[7:0], lf[15:8], n[0], (n % 5) == 0);
    end

    while (sbq.size() > 0 || !in_ready) @(negedge clk);
    repeat (300) @(negedge clk);
    check(nres == 41, "R9", "results per job", nres, 41);
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule